// File: doc/BRIEF.md
# Real-Time Clock User Register Snapshot and Transfer Control

This block sits between a byte-wide synchronous bus and a set of free-running calendar counters that it does not own. It keeps a separate user-visible copy of the seven time bytes (seconds, minutes, hours, weekday, date, month, year), plus one control byte. Once per second, on the counters' tick, the copy is refreshed as a whole. The counters themselves are never slowed, stopped or disturbed by bus traffic.

Software has two ways to hold the copy still. It can set a freeze bit to take a coherent snapshot for reading. It can also set a load bit, write new time values into the copy, and then clear the load bit. Clearing the load bit pushes the whole copy to the counters with a one-cycle strobe. The control byte also stores a signed calibration setting and passes it on. A separate oscillator-halt flag, kept in the top bit of the seconds byte, can be changed at any time.

The eight registers occupy the top eight addresses of the bus space. The offset is the address minus the highest address plus seven: offset 0 is control, offset 1 is seconds, and the offsets rise through minutes, hours, weekday, date and month to year at offset 7.

Top module: `rtc_snap_ctrl`

## Requirements
- R1: After reset the control byte reads 0x00, `load_stb` is 0, `cal_ctrl` is 0, `osc_stop` is 1 and bit 7 of the seconds register reads 1.
- R2: Only the top eight addresses are decoded (offset 0 control, 1 seconds, 2 minutes, 3 hours, 4 weekday, 5 date, 6 month, 7 year). Any other address reads 0x00, and a write to it changes no register.
- R3: Control bit 7 is the load bit, bit 6 the freeze bit, bit 5 the calibration sign and bits 4..0 the calibration magnitude. A control write takes effect at the next edge, reads back unchanged and drives `cal_ctrl` = control bits 5..0.
- R4: When neither the load bit nor the freeze bit is set, an edge with `sec_tick` high copies all seven counter bytes into the user copy at once. The new values are readable from the following cycle.
- R5: While the freeze bit is 1, ticks leave the user copy unchanged. Bus writes to time registers are also ignored unless the load bit is 1.
- R6: A control write that sets the freeze bit at the same edge as a tick does not cancel that tick's update.
- R7: While the load bit is 1, ticks leave the user copy unchanged, and bus writes to the time registers land in it and read back.
- R8: A control write with bit 7 = 0 while the load bit is 1 raises `load_stb` for exactly one cycle, starting the cycle after the write. During that cycle `load_time` holds the user copy: {year, month, date, weekday, hours, minutes, halt flag, seconds bits 6..0}. No other write produces the strobe.
- R9: With both bits set, clearing only the freeze bit keeps updates halted and gives no strobe. Clearing the load bit while the freeze bit stays set gives the strobe, and updates stay halted.
- R10: Once both bits are clear, the next tick refreshes the copy. A tick that coincides with the `load_stb` cycle is skipped.
- R11: A write to the seconds register always sets the halt flag from bit 7, whatever the control bits. The flag drives `osc_stop`, reads back as seconds bit 7, and no tick changes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Bus byte address |
| bus_wdata | input | 8 | Bus write data |
| bus_we | input | 1 | Bus write strobe, one byte per cycle |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| sec_tick | input | 1 | One-cycle pulse from the counters each second |
| cnt_time | input | 55 | Live counter values {year, month, date, weekday, hours, minutes, seconds[6:0]} |
| load_stb | output | 1 | One-cycle request to load the counters |
| load_time | output | 56 | Values to load, valid while `load_stb` is high |
| osc_stop | output | 1 | Oscillator halt flag |
| cal_ctrl | output | 6 | Calibration setting {sign, magnitude} |

## Verification
Every register write and every tick-driven copy is taken at the clock edge that samples it, and `bus_rdata` is combinational. A stimulus driven at a falling edge can therefore be read back at the next falling edge, one cycle later. `load_stb` rises at the edge that takes the clearing control write, and the bench samples it, together with `load_time`, half a cycle after that edge. It checks that the strobe has fallen one full cycle later. For the skipped-tick case, the tick is raised exactly in the strobe cycle, and the copy is read back one cycle later.

// File: rtl/rtc_snap_pkg.sv
package rtc_snap_pkg;

    localparam int BYTE_W   = 8;
    localparam int NUM_TIME = 7;
    localparam int SEC_W    = 7;
    localparam int TIME_W   = SEC_W + (NUM_TIME - 1) * BYTE_W;
    localparam int LOAD_W   = NUM_TIME * BYTE_W;
    localparam int CAL_W    = 6;

    typedef enum logic [2:0] {
        OFF_CTRL = 3'd0,
        OFF_SEC  = 3'd1,
        OFF_MIN  = 3'd2,
        OFF_HOUR = 3'd3,
        OFF_WDAY = 3'd4,
        OFF_DATE = 3'd5,
        OFF_MON  = 3'd6,
        OFF_YEAR = 3'd7
    } reg_off_e;

    typedef struct packed {
        logic       load_hold;
        logic       frz_hold;
        logic       cal_pos;
        logic [4:0] cal_mag;
    } ctrl_t;

    typedef struct packed {
        logic [7:0] year;
        logic [7:0] month;
        logic [7:0] date;
        logic [7:0] wday;
        logic [7:0] hour;
        logic [7:0] minute;
        logic [6:0] second;
    } time_t;

    function automatic int fld_lsb(int k);
        return (k == 0) ? 0 : (k * BYTE_W - 1);
    endfunction

    function automatic int fld_w(int k);
        return (k == 0) ? SEC_W : BYTE_W;
    endfunction

    function automatic logic [7:0] read_byte(time_t t, ctrl_t c, logic stop, reg_off_e off);
        logic [7:0] r;
        case (off)
            OFF_CTRL: r = c;
            OFF_SEC:  r = {stop, t.second};
            OFF_MIN:  r = t.minute;
            OFF_HOUR: r = t.hour;
            OFF_WDAY: r = t.wday;
            OFF_DATE: r = t.date;
            OFF_MON:  r = t.month;
            default:  r = t.year;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rtc_bus_decode.sv
module rtc_bus_decode
    import rtc_snap_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    output logic              hit,
    output reg_off_e          off,
    output logic              wr_ctrl,
    output logic              wr_sec,
    output logic              wr_any
);
    localparam int OFF_W = 3;

    assign hit     = &bus_addr[ADDR_W-1:OFF_W];
    assign off     = reg_off_e'(bus_addr[OFF_W-1:0]);
    assign wr_any  = bus_we && hit;
    assign wr_ctrl = wr_any && (off == OFF_CTRL);
    assign wr_sec  = wr_any && (off == OFF_SEC);
endmodule

// File: rtl/rtc_ctrl_reg.sv
module rtc_ctrl_reg
    import rtc_snap_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_ctrl,
    input  logic       wr_sec,
    input  logic [7:0] wdata,
    output ctrl_t      ctrl_q,
    output logic       stop_q,
    output logic       commit_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            stop_q   <= 1'b1;
            commit_q <= 1'b0;
        end else begin
            commit_q <= wr_ctrl && ctrl_q.load_hold && !wdata[7];
            if (wr_ctrl) ctrl_q <= ctrl_t'(wdata);
            if (wr_sec)  stop_q <= wdata[7];
        end
    end
endmodule

// File: rtl/rtc_time_shadow.sv
module rtc_time_shadow
    import rtc_snap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              upd_en,
    input  logic              wr_en,
    input  reg_off_e          wr_off,
    input  logic [7:0]        wr_data,
    input  logic [TIME_W-1:0] cnt_time,
    output logic [TIME_W-1:0] shadow
);
    for (genvar k = 0; k < NUM_TIME; k++) begin : g_field
        localparam int LSB = fld_lsb(k);
        localparam int W   = fld_w(k);
        logic [W-1:0] q;

        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (wr_en && (wr_off == reg_off_e'(k + 1))) begin
                q <= wr_data[W-1:0];
            end else if (upd_en) begin
                q <= cnt_time[LSB +: W];
            end
        end

        assign shadow[LSB +: W] = q;
    end
endmodule

// File: rtl/rtc_snap_ctrl.sv
module rtc_snap_ctrl
    import rtc_snap_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_we,
    output logic [7:0]        bus_rdata,
    input  logic              sec_tick,
    input  logic [TIME_W-1:0] cnt_time,
    output logic              load_stb,
    output logic [LOAD_W-1:0] load_time,
    output logic              osc_stop,
    output logic [CAL_W-1:0]  cal_ctrl
);
    logic              hit;
    reg_off_e          off;
    logic              wr_ctrl;
    logic              wr_sec;
    logic              wr_any;
    ctrl_t             ctrl_q;
    logic              stop_q;
    logic              commit_q;
    logic              halted;
    logic              upd_en;
    logic              wr_time;
    logic [TIME_W-1:0] shadow;
    time_t             sh_t;

    rtc_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .hit      (hit),
        .off      (off),
        .wr_ctrl  (wr_ctrl),
        .wr_sec   (wr_sec),
        .wr_any   (wr_any)
    );

    rtc_ctrl_reg u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .wr_ctrl  (wr_ctrl),
        .wr_sec   (wr_sec),
        .wdata    (bus_wdata),
        .ctrl_q   (ctrl_q),
        .stop_q   (stop_q),
        .commit_q (commit_q)
    );

    // halt is the register value before this edge, so a same-edge halt still lets a tick through
    assign halted  = ctrl_q.load_hold || ctrl_q.frz_hold;
    assign upd_en  = sec_tick && !halted && !commit_q;
    assign wr_time = wr_any && ctrl_q.load_hold;

    rtc_time_shadow u_shadow (
        .clk      (clk),
        .rst      (rst),
        .upd_en   (upd_en),
        .wr_en    (wr_time),
        .wr_off   (off),
        .wr_data  (bus_wdata),
        .cnt_time (cnt_time),
        .shadow   (shadow)
    );

    assign sh_t = time_t'(shadow);

    always_comb begin
        bus_rdata = '0;
        if (hit) bus_rdata = read_byte(sh_t, ctrl_q, stop_q, off);
    end

    // shadow is frozen during the strobe cycle (writes closed, tick suppressed), so no capture flop
    assign load_time = {sh_t.year, sh_t.month, sh_t.date, sh_t.wday,
                        sh_t.hour, sh_t.minute, stop_q, sh_t.second};
    assign load_stb  = commit_q;
    assign osc_stop  = stop_q;
    assign cal_ctrl  = {ctrl_q.cal_pos, ctrl_q.cal_mag};
endmodule

// File: rtl/rtc_snap_ctrl_chk.sv
module rtc_snap_ctrl_chk #(
    parameter int ADDR_W = 19
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic              bus_we,
    input logic              load_stb,
    input logic              osc_stop,
    input logic [5:0]        cal_ctrl
);
    localparam logic [ADDR_W-1:0] CTRL_A = {{(ADDR_W-3){1'b1}}, 3'd0};
    localparam logic [ADDR_W-1:0] SEC_A  = {{(ADDR_W-3){1'b1}}, 3'd1};

    logic ctrl_wr;
    logic sec_wr;
    assign ctrl_wr = bus_we && (bus_addr == CTRL_A);
    assign sec_wr  = bus_we && (bus_addr == SEC_A);

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!load_stb && osc_stop && cal_ctrl == 6'd0));

    p_cal_source_r3: assert property (@(posedge clk) disable iff (rst)
        !$stable(cal_ctrl) |-> ($past(ctrl_wr) && cal_ctrl == $past(bus_wdata[5:0])));

    p_strobe_single_r8: assert property (@(posedge clk) disable iff (rst)
        load_stb |=> !load_stb);

    p_strobe_cause_r8: assert property (@(posedge clk) disable iff (rst)
        load_stb |-> ($past(ctrl_wr) && !$past(bus_wdata[7])));

    p_stop_source_r11: assert property (@(posedge clk) disable iff (rst)
        !$stable(osc_stop) |-> ($past(sec_wr) && osc_stop == $past(bus_wdata[7])));
endmodule

bind rtc_snap_ctrl rtc_snap_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .load_stb  (load_stb),
    .osc_stop  (osc_stop),
    .cal_ctrl  (cal_ctrl)
);

// File: tb/rtc_snap_ctrl_tb.sv
module rtc_snap_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 19;
    localparam logic [ADDR_W-1:0] BASE = {{(ADDR_W-3){1'b1}}, 3'd0};
    localparam logic [ADDR_W-1:0] A_CTRL = BASE;
    localparam logic [ADDR_W-1:0] A_SEC  = BASE + 1;
    localparam logic [ADDR_W-1:0] A_MIN  = BASE + 2;
    localparam logic [ADDR_W-1:0] A_YEAR = BASE + 7;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [7:0]        bus_wdata = '0;
    logic              bus_we = 1'b0;
    logic [7:0]        bus_rdata;
    logic              sec_tick = 1'b0;
    logic [54:0]       cnt_time = '0;
    logic              load_stb;
    logic [55:0]       load_time;
    logic              osc_stop;
    logic [5:0]        cal_ctrl;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_snap_ctrl #(.ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .sec_tick(sec_tick),
        .cnt_time(cnt_time), .load_stb(load_stb), .load_time(load_time),
        .osc_stop(osc_stop), .cal_ctrl(cal_ctrl)
    );

    function automatic logic [54:0] mk(logic [7:0] y, logic [7:0] mo, logic [7:0] dt,
                                       logic [7:0] wd, logic [7:0] h, logic [7:0] mi, logic [6:0] s);
        return {y, mo, dt, wd, h, mi, s};
    endfunction

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // one bus/tick cycle: drive at a falling edge, sampled at the next rising edge
    task automatic cyc(logic we, logic [ADDR_W-1:0] a, logic [7:0] d, logic tk);
        @(negedge clk);
        bus_we = we; bus_addr = a; bus_wdata = d; sec_tick = tk;
        @(negedge clk);
        bus_we = 1'b0; sec_tick = 1'b0;
    endtask

    task automatic wr(logic [ADDR_W-1:0] a, logic [7:0] d);
        cyc(1'b1, a, d, 1'b0);
    endtask

    task automatic tick(logic [54:0] v);
        cnt_time = v;
        cyc(1'b0, A_CTRL, 8'h00, 1'b1);
    endtask

    task automatic rd(logic [ADDR_W-1:0] a, output logic [7:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic expect_time(string req, logic [54:0] e);
        logic [7:0] v;
        logic [7:0] ex;
        for (int k = 0; k < 7; k++) begin
            rd(BASE + ADDR_W'(k + 1), v);
            if (k == 0) begin
                v  = {1'b0, v[6:0]};
                ex = {1'b0, e[6:0]};
            end else begin
                ex = 8'(e >> (8 * k - 1));
            end
            check(req, $sformatf("time byte offset %0d", k + 1), 64'(v), 64'(ex));
        end
    endtask

    localparam logic [54:0] TA = 55'h0;

    logic [54:0] va, vb, vc, vd, ve, vw, vg, vh, vj, vk;

    task automatic t_reset();
        logic [7:0] v;
        rd(A_CTRL, v);
        check("R1", "control after reset", 64'(v), 64'h00);
        rd(A_SEC, v);
        check("R1", "seconds bit7 after reset", 64'(v[7]), 64'd1);
        check("R1", "load_stb after reset", 64'(load_stb), 64'd0);
        check("R1", "osc_stop after reset", 64'(osc_stop), 64'd1);
        check("R1", "cal_ctrl after reset", 64'(cal_ctrl), 64'd0);
    endtask

    task automatic t_update();
        tick(va);
        expect_time("R4", va);
    endtask

    task automatic t_unmapped();
        logic [7:0] v;
        rd(BASE - 1, v);
        check("R2", "read below block", 64'(v), 64'h00);
        wr(BASE - 8, 8'hFF);
        rd(A_CTRL, v);
        check("R2", "alias write leaves control", 64'(v), 64'h00);
        check("R2", "alias write leaves cal", 64'(cal_ctrl), 64'd0);
    endtask

    task automatic t_cal();
        logic [7:0] v;
        wr(A_CTRL, 8'h3A);
        rd(A_CTRL, v);
        check("R3", "control readback", 64'(v), 64'h3A);
        check("R3", "cal_ctrl output", 64'(cal_ctrl), 64'h3A);
        check("R3", "no strobe from cal write", 64'(load_stb), 64'd0);
        wr(A_CTRL, 8'h00);
    endtask

    task automatic t_freeze();
        wr(A_CTRL, 8'h40);
        tick(vb);
        expect_time("R5", va);
        wr(A_YEAR, 8'h55);
        expect_time("R5", va);
        wr(A_CTRL, 8'h00);
        check("R10", "no strobe when freeze cleared", 64'(load_stb), 64'd0);
        tick(vc);
        expect_time("R10", vc);
    endtask

    task automatic t_same_edge();
        cnt_time = vd;
        cyc(1'b1, A_CTRL, 8'h40, 1'b1);
        expect_time("R6", vd);
        tick(ve);
        expect_time("R6", vd);
        wr(A_CTRL, 8'h00);
    endtask

    task automatic t_stop();
        logic [7:0] v;
        wr(A_SEC, 8'h7F);
        check("R11", "osc_stop cleared by seconds write", 64'(osc_stop), 64'd0);
        rd(A_SEC, v);
        check("R11", "seconds readback", 64'(v), 64'({1'b0, vd[6:0]}));
    endtask

    task automatic t_load();
        logic [7:0] v;
        wr(A_CTRL, 8'h80);
        tick(vd ^ 55'h1);
        expect_time("R7", vd);
        wr(A_SEC, 8'h45);
        wr(A_MIN, 8'h30);
        wr(A_YEAR, 8'h99);
        expect_time("R7", vw);
        rd(A_SEC, v);
        check("R11", "halt flag kept through load-mode seconds write", 64'(osc_stop), 64'd0);
        wr(A_CTRL, 8'h00);
        check("R8", "strobe after load bit cleared", 64'(load_stb), 64'd1);
        check("R8", "load_time", 64'(load_time), 64'({vw[54:7], 1'b0, vw[6:0]}));
        #(CLK_PERIOD);
        check("R8", "strobe lasts one cycle", 64'(load_stb), 64'd0);
    endtask

    task automatic t_both();
        wr(A_CTRL, 8'hC0);
        wr(A_CTRL, 8'h80);
        check("R9", "no strobe clearing freeze only", 64'(load_stb), 64'd0);
        tick(vg);
        expect_time("R9", vw);
        wr(A_CTRL, 8'h40);
        check("R9", "strobe clearing load with freeze set", 64'(load_stb), 64'd1);
        tick(vg);
        expect_time("R9", vw);
        wr(A_CTRL, 8'h00);
        tick(vh);
        expect_time("R10", vh);
    endtask

    task automatic t_strobe_tick();
        wr(A_CTRL, 8'h80);
        wr(A_CTRL, 8'h00);
        check("R8", "strobe before skipped tick", 64'(load_stb), 64'd1);
        cnt_time = vj;
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
        expect_time("R10", vh);
        tick(vk);
        expect_time("R10", vk);
    endtask

    initial begin
        va = mk(8'h24, 8'h06, 8'h15, 8'h03, 8'h13, 8'h47, 7'h21);
        vb = mk(8'h25, 8'h07, 8'h16, 8'h04, 8'h14, 8'h48, 7'h22);
        vc = mk(8'h26, 8'h08, 8'h17, 8'h05, 8'h15, 8'h49, 7'h23);
        vd = mk(8'h27, 8'h09, 8'h18, 8'h06, 8'h16, 8'h50, 7'h24);
        ve = mk(8'h28, 8'h10, 8'h19, 8'h07, 8'h17, 8'h51, 7'h25);
        vw = {8'h99, vd[46:15], 8'h30, 7'h45};
        vg = mk(8'h31, 8'h11, 8'h20, 8'h01, 8'h18, 8'h52, 7'h26);
        vh = mk(8'h32, 8'h12, 8'h21, 8'h02, 8'h19, 8'h53, 7'h27);
        vj = mk(8'h33, 8'h01, 8'h22, 8'h03, 8'h20, 8'h54, 7'h28);
        vk = mk(8'h34, 8'h02, 8'h23, 8'h04, 8'h21, 8'h55, 7'h29);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_unmapped();
        t_update();
        t_cal();
        t_freeze();
        t_same_edge();
        t_stop();
        t_load();
        t_both();
        t_strobe_tick();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    wire unused_ta = ^TA;
endmodule